// File: doc/BRIEF.md
# Dispatch Group Slot Tracker

This block follows an in-order front end as it packs instructions into dispatch groups. Each accepted instruction arrives with a two-bit class code, a branch flag, a record-form flag and a tag. The block charges the instruction a number of slots according to its class. It decides whether the instruction has to open a fresh group or cannot join one at all. It keeps the running slot count, the branch count and the list of tags that belong to the current group.

The tracker also answers three questions about the present group, each combinationally. The first is whether a candidate instruction would prefer to wait, because it must lead a group that is already open. The second is how many padding no-ops to insert when the scheduler raises a load-after-store hazard. The third is whether a given tag is a member of the current group. A mode input says whether a single group-terminating no-op exists. That mode changes both the padding count and the way an emitted no-op affects the group. Decoding classes from opcodes and finding dependencies happen elsewhere and reach the block as flags.

Top module: `dgt_slot_tracker`

## Requirements
- R1: Slot cost by class code: 0 costs 1, 1 costs 2, 2 costs 4, 3 costs 1. When an instruction of cost 1 has the record-form flag set, it is charged 2 instead. On a normal join the slot count rises by the cost.
- R2: An instruction must lead its group if its cost is above 1 or its class is 3. If it arrives while the slot count is nonzero, the group is first emptied, and the slot count then equals its cost.
- R3: An issued instruction that finds the slot count at 5 or more is not counted. The same holds for a branch that finds the branch count at 1. In both cases the group is emptied, both counts become 0, and the instruction's tag is not a member.
- R4: A joining branch adds 1 to the branch count, after any restart from R2. The branch count never exceeds 1.
- R5: The pad count is 0 when the hazard flag is low. When the flag is high and the slot count is below 6, the pad count is 1 in terminating mode and 5 minus the slot count otherwise. When the flag is high at a slot count of 6, the pad count is 0.
- R6: An emitted no-op empties the group if terminating mode is on or the slot count is 6. Otherwise it adds 1 to the slot count and occupies an entry that matches no tag.
- R7: prefer_other is high exactly when the candidate class and record flag describe an instruction that must lead, and the slot count is nonzero.
- R8: query_hit is high exactly when the queried tag belongs to an instruction that joined the current group and has not been removed by a clear.
- R9: A synchronous reset sets the slot count and the branch count to 0 and empties the membership list.
- R10: When issue_valid and nop_valid are high in the same cycle, only the instruction is processed and the no-op is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | An instruction is issued this cycle |
| issue_class | input | 2 | Class code of the issued instruction |
| issue_branch | input | 1 | Issued instruction is a branch |
| issue_record | input | 1 | Issued instruction is record form |
| issue_tag | input | TAG_W | Tag of the issued instruction |
| nop_valid | input | 1 | A padding no-op is emitted this cycle |
| term_nop_mode | input | 1 | A single group-terminating no-op is available |
| hazard_flag | input | 1 | Next instruction carries a load-after-store hazard |
| cand_class | input | 2 | Class code of the candidate for the prefer hint |
| cand_record | input | 1 | Candidate is record form |
| query_tag | input | TAG_W | Tag looked up in the current group |
| slot_count | output | 3 | Slots used by the current group |
| branch_count | output | 2 | Branches in the current group |
| pad_nops | output | 3 | Number of no-ops to insert |
| prefer_other | output | 1 | Candidate should be held back |
| query_hit | output | 1 | query_tag is a member of the current group |

## Verification
The hardest states to reach are a slot count of 6, and a slot count of 5 with a no-op following it. A count of 6 exists only after a no-op fills the last normal slot in non-terminating mode. These are also the only states in which the no-op closing rule and the zero-pad rule matter. The stimulus is a long pseudo-random stream that mixes cost-1 issues, no-ops, both modes and simultaneous issue/no-op cycles, so the count keeps climbing through every value from 0 to 6. In every cycle the bench sweeps all candidate encodings, all hazard/mode pairs and all tags against its own model of the group.

// File: rtl/dgt_pkg.sv
package dgt_pkg;
  localparam int unsigned CLASS_W    = 2;
  localparam int unsigned SLOT_W     = 3;
  localparam int unsigned BR_W       = 2;
  localparam int unsigned GROUP_FULL = 5;
  localparam int unsigned GROUP_CEIL = 6;

  typedef enum logic [CLASS_W-1:0] {
    CLS_PLAIN  = 2'd0,
    CLS_DOUBLE = 2'd1,
    CLS_QUAD   = 2'd2,
    CLS_LEAD   = 2'd3
  } dgt_class_e;

  // slots charged for one instruction
  function automatic logic [SLOT_W-1:0] slot_cost(input logic [CLASS_W-1:0] cls,
                                                  input logic rec);
    logic [SLOT_W-1:0] c;
    unique case (dgt_class_e'(cls))
      CLS_DOUBLE: c = SLOT_W'(2);
      CLS_QUAD:   c = SLOT_W'(4);
      default:    c = SLOT_W'(1);
    endcase
    if (c == SLOT_W'(1) && rec) c = SLOT_W'(2);
    return c;
  endfunction

  function automatic logic must_lead(input logic [CLASS_W-1:0] cls, input logic rec);
    return (slot_cost(cls, rec) > SLOT_W'(1)) || (dgt_class_e'(cls) == CLS_LEAD);
  endfunction

  // padding no-ops for a hazard
  function automatic logic [SLOT_W-1:0] pad_count(input logic hz, input logic term,
                                                  input logic [SLOT_W-1:0] slots);
    if (!hz || slots >= SLOT_W'(GROUP_CEIL)) return '0;
    if (term) return SLOT_W'(1);
    return SLOT_W'(GROUP_FULL) - slots;
  endfunction
endpackage

// File: rtl/dgt_cost_decode.sv
module dgt_cost_decode
  import dgt_pkg::*;
(
  input  logic [CLASS_W-1:0] cls,
  input  logic               rec,
  output logic [SLOT_W-1:0]  cost,
  output logic               lead
);
  assign cost = slot_cost(cls, rec);
  assign lead = must_lead(cls, rec);
endmodule

// File: rtl/dgt_roster.sv
module dgt_roster #(
  parameter int unsigned TAG_W = 4,
  parameter int unsigned DEPTH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             push,
  input  logic             push_real,
  input  logic [TAG_W-1:0] push_tag,
  input  logic [TAG_W-1:0] query_tag,
  output logic             query_hit
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] base;
  logic [DEPTH-1:0] valid;
  logic [TAG_W-1:0] tags [DEPTH];
  logic [DEPTH-1:0] hit_vec;
  logic             room;
  logic [IDX_W-1:0] widx;

  assign base = clear ? '0 : count;
  assign room = base < CNT_W'(DEPTH);
  assign widx = IDX_W'(base);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      valid <= '0;
    end else begin
      if (clear) valid <= '0;
      if (push && room) begin
        tags[widx]  <= push_tag;
        valid[widx] <= push_real;
        count       <= base + CNT_W'(1);
      end else begin
        count <= base;
      end
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign hit_vec[i] = valid[i] && (tags[i] == query_tag);
    end
  endgenerate

  assign query_hit = |hit_vec;
endmodule

// File: rtl/dgt_slot_tracker.sv
module dgt_slot_tracker
  import dgt_pkg::*;
#(
  parameter int unsigned TAG_W = 4,
  parameter int unsigned DEPTH = GROUP_CEIL
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               issue_valid,
  input  logic [CLASS_W-1:0] issue_class,
  input  logic               issue_branch,
  input  logic               issue_record,
  input  logic [TAG_W-1:0]   issue_tag,
  input  logic               nop_valid,
  input  logic               term_nop_mode,
  input  logic               hazard_flag,
  input  logic [CLASS_W-1:0] cand_class,
  input  logic               cand_record,
  input  logic [TAG_W-1:0]   query_tag,
  output logic [SLOT_W-1:0]  slot_count,
  output logic [BR_W-1:0]    branch_count,
  output logic [SLOT_W-1:0]  pad_nops,
  output logic               prefer_other,
  output logic               query_hit
);
  logic [SLOT_W-1:0] issue_cost, cand_cost;
  logic              issue_lead, cand_lead;

  dgt_cost_decode u_issue_dec (.cls(issue_class), .rec(issue_record),
                               .cost(issue_cost), .lead(issue_lead));
  dgt_cost_decode u_cand_dec  (.cls(cand_class),  .rec(cand_record),
                               .cost(cand_cost),  .lead(cand_lead));

  // named group events
  logic ov_close, lead_restart, issue_join, nop_evt, nop_close, nop_fill, group_clear;

  assign ov_close     = issue_valid && ((slot_count >= SLOT_W'(GROUP_FULL)) ||
                                        (issue_branch && branch_count == BR_W'(1)));
  assign issue_join   = issue_valid && !ov_close;
  assign lead_restart = issue_join && issue_lead && (slot_count != '0);
  assign nop_evt      = nop_valid && !issue_valid;
  assign nop_close    = nop_evt && (term_nop_mode || slot_count == SLOT_W'(GROUP_CEIL));
  assign nop_fill     = nop_evt && !nop_close;
  assign group_clear  = ov_close || lead_restart || nop_close;

  logic [SLOT_W-1:0] slot_next;
  logic [BR_W-1:0]   br_next;

  always_comb begin
    slot_next = slot_count;
    br_next   = branch_count;
    if (ov_close || nop_close) begin
      slot_next = '0;
      br_next   = '0;
    end else if (issue_join) begin
      slot_next = (lead_restart ? '0 : slot_count) + issue_cost;
      br_next   = (lead_restart ? '0 : branch_count) + BR_W'(issue_branch);
    end else if (nop_fill) begin
      slot_next = slot_count + SLOT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_count   <= '0;
      branch_count <= '0;
    end else begin
      slot_count   <= slot_next;
      branch_count <= br_next;
    end
  end

  dgt_roster #(.TAG_W(TAG_W), .DEPTH(DEPTH)) u_roster (
    .clk       (clk),
    .rst       (rst),
    .clear     (group_clear),
    .push      (issue_join || nop_fill),
    .push_real (issue_join),
    .push_tag  (issue_tag),
    .query_tag (query_tag),
    .query_hit (query_hit)
  );

  assign pad_nops     = pad_count(hazard_flag, term_nop_mode, slot_count);
  assign prefer_other = cand_lead && (slot_count != '0);

  logic unused_cost;
  assign unused_cost = ^cand_cost;
endmodule

// File: rtl/dgt_slot_tracker_chk.sv
module dgt_slot_tracker_chk
  import dgt_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              issue_valid,
  input logic              issue_branch,
  input logic [SLOT_W-1:0] issue_cost,
  input logic              lead_restart,
  input logic              nop_valid,
  input logic              term_nop_mode,
  input logic              hazard_flag,
  input logic [SLOT_W-1:0] slot_count,
  input logic [BR_W-1:0]   branch_count,
  input logic [SLOT_W-1:0] pad_nops,
  input logic              prefer_other,
  input logic              query_hit
);
  // R3
  full_close_chk: assert property (@(posedge clk) disable iff (rst)
    issue_valid && slot_count >= SLOT_W'(GROUP_FULL) |=> slot_count == '0 && branch_count == '0);
  // R3
  dup_branch_chk: assert property (@(posedge clk) disable iff (rst)
    issue_valid && issue_branch && branch_count == BR_W'(1) |=> slot_count == '0);
  // R2
  lead_restart_chk: assert property (@(posedge clk) disable iff (rst)
    lead_restart |=> slot_count == $past(issue_cost));
  // R4
  branch_bound_chk: assert property (@(posedge clk) disable iff (rst)
    branch_count <= BR_W'(1) && slot_count <= SLOT_W'(GROUP_CEIL));
  // R6
  nop_close_chk: assert property (@(posedge clk) disable iff (rst)
    nop_valid && !issue_valid && term_nop_mode |=> slot_count == '0);
  // R6
  nop_fill_chk: assert property (@(posedge clk) disable iff (rst)
    nop_valid && !issue_valid && !term_nop_mode && slot_count < SLOT_W'(GROUP_CEIL)
    |=> slot_count == $past(slot_count) + SLOT_W'(1));
  // R5
  pad_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !hazard_flag |-> pad_nops == '0);
  // R5
  pad_term_chk: assert property (@(posedge clk) disable iff (rst)
    hazard_flag && term_nop_mode && slot_count < SLOT_W'(GROUP_CEIL) |-> pad_nops == SLOT_W'(1));
  // R7
  prefer_open_chk: assert property (@(posedge clk) disable iff (rst)
    prefer_other |-> slot_count != '0);
  // R8
  empty_group_chk: assert property (@(posedge clk) disable iff (rst)
    slot_count == '0 |-> !query_hit);
  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> slot_count == '0 && branch_count == '0);
endmodule

bind dgt_slot_tracker dgt_slot_tracker_chk u_chk (
  .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_branch(issue_branch),
  .issue_cost(issue_cost), .lead_restart(lead_restart), .nop_valid(nop_valid),
  .term_nop_mode(term_nop_mode), .hazard_flag(hazard_flag), .slot_count(slot_count),
  .branch_count(branch_count), .pad_nops(pad_nops), .prefer_other(prefer_other),
  .query_hit(query_hit)
);

// File: tb/dgt_slot_tracker_test.sv
`timescale 1ns/1ps
module dgt_slot_tracker_test;
  localparam int TAG_W = 4;
  localparam int NCYC  = 3000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, issue_valid, issue_branch, issue_record, nop_valid, term_nop_mode;
  logic hazard_flag, cand_record, prefer_other, query_hit;
  logic [1:0] issue_class, cand_class, branch_count;
  logic [TAG_W-1:0] issue_tag, query_tag;
  logic [2:0] slot_count, pad_nops;

  dgt_slot_tracker #(.TAG_W(TAG_W)) uut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench model of the group
  int m_slots, m_brs, m_cnt;
  int m_tag [8];
  bit m_real [8];
  string last_req;

  function automatic int cost_of(int cls, bit rec);
    int c;
    c = (cls == 1 || cls == 2) ? (1 << cls) : 1;
    if (c == 1 && rec) c = 2;
    return c;
  endfunction

  function automatic bit leads(int cls, bit rec);
    return cost_of(cls, rec) != 1 || cls == 3;
  endfunction

  function automatic void m_clear();
    m_slots = 0; m_brs = 0; m_cnt = 0;
  endfunction

  function automatic void m_step(bit r, bit iv, int cls, bit br, bit rec, int tg, bit nv, bit term);
    if (r) begin m_clear(); last_req = "R9"; return; end
    if (iv) begin
      last_req = nv ? "R10" : "R1";
      if (m_slots >= 5 || (br && m_brs == 1)) begin m_clear(); last_req = "R3"; return; end
      if (leads(cls, rec) && m_slots != 0) begin m_clear(); last_req = "R2"; end
      m_slots += cost_of(cls, rec);
      m_brs += br;
      m_tag[m_cnt] = tg; m_real[m_cnt] = 1; m_cnt++;
    end else if (nv) begin
      last_req = "R6";
      if (term || m_slots == 6) m_clear();
      else begin m_real[m_cnt] = 0; m_tag[m_cnt] = 0; m_cnt++; m_slots++; end
    end else last_req = "R1";
  endfunction

  function automatic bit m_member(int tg);
    for (int k = 0; k < m_cnt; k++) if (m_real[k] && m_tag[k] == tg) return 1;
    return 0;
  endfunction

  task automatic sweep_comb();
    int exp_pad;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 2; r++) begin
        cand_class = 2'(c); cand_record = r[0];
        #0.05 chk("R7 prefer", prefer_other, (leads(c, r[0]) && m_slots != 0));
      end
    for (int h = 0; h < 2; h++)
      for (int t = 0; t < 2; t++) begin
        hazard_flag = h[0]; term_nop_mode = t[0];
        if (h == 0 || m_slots >= 6) exp_pad = 0;
        else exp_pad = t ? 1 : 5 - m_slots;
        #0.05 chk("R5 pad", pad_nops, exp_pad);
      end
    for (int q = 0; q < (1 << TAG_W); q++) begin
      query_tag = TAG_W'(q);
      #0.05 chk("R8 member", query_hit, m_member(q));
    end
  endtask

  bit [31:0] lfsr = 32'h1ACE_5EED;
  function automatic bit [31:0] rnd();
    lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
    return lfsr;
  endfunction

  initial begin
    #(4 * (NCYC + 200));
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit [31:0] v;
    int kind, cls, tg;
    bit br, rec, term;
    rst = 1; issue_valid = 0; issue_class = 0; issue_branch = 0; issue_record = 0;
    issue_tag = 0; nop_valid = 0; term_nop_mode = 0; hazard_flag = 0;
    cand_class = 0; cand_record = 0; query_tag = 0;
    m_clear();
    @(negedge clk); @(negedge clk);
    chk("R9 reset slots", slot_count, 0);
    chk("R9 reset branches", branch_count, 0);
    sweep_comb();
    rst = 0;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      v = rnd();
      kind = int'(v[3:0]);
      cls  = int'(v[5:4]);
      // bias toward cheap instructions so the count climbs
      if (v[8:6] != 3'd0) cls = 0;
      br   = (v[11:9] == 3'd0);
      rec  = v[12] && v[13];
      term = (v[15:14] == 2'd0);
      tg   = int'(v[19:16]);
      rst          = (cyc == NCYC / 2);
      issue_valid  = (kind < 9) || (kind == 15);
      nop_valid    = (kind >= 9 && kind < 13) || (kind == 15);
      issue_class  = 2'(cls);
      issue_branch = br;
      issue_record = rec;
      issue_tag    = TAG_W'(tg);
      term_nop_mode = term;
      m_step(rst, issue_valid, cls, br, rec, tg, nop_valid, term);
      @(negedge clk);
      chk({last_req, " slots"}, slot_count, m_slots);
      chk({(last_req == "R1") ? "R4" : last_req, " branches"}, branch_count, m_brs);
      sweep_comb();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule